// File: doc/BRIEF.md
# Command/Response Buffer Register Slave

This block is the device-side register file of a memory-mapped command/response
interface for a security coprocessor. A host reaches it through a simple 32-bit
register bus with one write strobe and a combinational read path. The host first
claims the single locality. It then steers the device between an idle and a
ready state, fills a small byte window with a command, and launches it by
setting start. Command execution is modelled as a countdown whose length comes
from the `exec_cycles` input. When the countdown ends, the device writes a fixed
response header into the window and clears start. A cancel bit aborts a command
that is running.

There are three state machines. The locality machine has the states FREE,
PENDING and OWNED. A request moves it FREE→PENDING. After `GRANT_DLY` cycles it
moves PENDING→OWNED. A relinquish moves it PENDING→FREE or OWNED→FREE. The
control machine has the states IDLE, READY and EXEC. A pending go-ready request
moves it IDLE→READY. A pending go-idle request moves it READY→IDLE. An accepted
start moves it READY→EXEC. It returns EXEC→READY either when the countdown
expires (completion) or when cancel is set (abort). The buffer descriptors are
constants that describe one shared region at `BUF_BASE + 0x80`, with equal
command and response sizes. Address bits [1:0] are ignored.

Top module: `crb_regslave`

## Requirements
- R1: After reset the registers read as follows. Locality state (0x00) reads 0x80: valid, not assigned, not established. Status (0x44) reads 0x2, the idle flag. Start (0x4C) reads 0. Interface ID (0x30) reads 1. Both sizes (0x58, 0x64) read `BUF_BYTES`. The address words (0x5C/0x68 low, 0x60/0x6C high) read `BUF_BASE + 0x80`.
- R2: Writing bit 0 of locality control (0x08) while the locality is free has these effects. Valid (bit 7 of 0x00) reads 0 while the grant is pending. Exactly `GRANT_DLY` cycles after the write, assigned (bit 1 of 0x00) and granted (bit 0 of 0x0C) read 1. Established (bit 0 of 0x00) is then set, and it stays set until reset.
- R3: Writing bit 1 of 0x08 frees the locality one cycle after the write, whether the grant is pending or owned. Relinquish wins over a request made in the same write.
- R4: Request register 0x40 has two bits: bit 0 asks for ready and bit 1 asks for idle. Written bits read back for one cycle. They then self-clear while the device acts on them. The status idle flag (bit 1 of 0x44) reads 1 exactly in the idle state.
- R5: A start write (bit 0 of 0x4C) is accepted only in the ready state, with the locality owned. Start then reads 1 for L+1 cycles, where L is `exec_cycles` at the write, and then reads 0 in the ready state.
- R6: A start write made while owned but outside the ready state is dropped and sets the error flag (bit 0 of 0x44). The error flag clears when the device moves from ready to idle.
- R7: Setting bit 0 of cancel (0x48) during execution clears start one cycle after the write. No response header is written. Cancel reads back until the host writes it to 0.
- R8: On completion the device writes a 10-byte header. Byte 0 is 0x80 and byte 1 is 0x01. Bytes 2..5 hold the value 10 in big-endian order. Bytes 6..9 are zero. Bytes past the header keep their values. Byte 4i sits in bits 7:0 of the word at 0x80+4i.
- R9: While the locality is not owned, writes to 0x40, 0x48, 0x4C and the data window have no effect.
- R10: Data window writes made during execution are dropped.
- R11: Only bit 31 of interrupt enable (0x50) is stored, and its other bits read 0. Writes to read-only registers are dropped. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| exec_cycles | input | LAT_W | Execution latency, sampled when start is accepted |

## Verification
A behavioural model in the bench predicts the read value at the current address, and the bench compares it with the design on every clock. The stimulus runs the handshake with three latencies. A long latency shows that start stays set for the full countdown. A zero latency shows the one-cycle boundary. A long latency cut short by cancel separates an abort from a completion by whether the header appears. Start writes made in the wrong state or without the locality separate a dropped start that sets the error flag from a silent one.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_READY = 2'd1,
        CS_EXEC  = 2'd2
    } ctrl_state_e;

    typedef enum logic [1:0] {
        LS_FREE  = 2'd0,
        LS_PEND  = 2'd1,
        LS_OWNED = 2'd2
    } loc_state_e;

    // byte offsets of the register map
    localparam int OFS_LOC_STATE = 'h00;
    localparam int OFS_LOC_CTRL  = 'h08;
    localparam int OFS_LOC_STS   = 'h0C;
    localparam int OFS_IFACE_ID  = 'h30;
    localparam int OFS_CTRL_EXT  = 'h38;
    localparam int OFS_REQ       = 'h40;
    localparam int OFS_STS       = 'h44;
    localparam int OFS_CANCEL    = 'h48;
    localparam int OFS_START     = 'h4C;
    localparam int OFS_IEN       = 'h50;
    localparam int OFS_ISTS      = 'h54;
    localparam int OFS_CMD_SIZE  = 'h58;
    localparam int OFS_CMD_LO    = 'h5C;
    localparam int OFS_CMD_HI    = 'h60;
    localparam int OFS_RSP_SIZE  = 'h64;
    localparam int OFS_RSP_LO    = 'h68;
    localparam int OFS_RSP_HI    = 'h6C;
    localparam int OFS_DATA      = 'h80;

    localparam int HDR_BYTES = 10;

    // canned response header: tag 0x8001, big-endian length, zero code
    function automatic logic [7:0] hdr_byte(input int idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'h80;
            1:       v = 8'h01;
            5:       v = 8'(HDR_BYTES);
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/crb_locality.sv
module crb_locality
    import crb_pkg::*;
#(
    parameter int GRANT_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rel_i,
    output logic owned_o,
    output logic valid_o,
    output logic estab_o
);
    localparam int CW = $clog2(GRANT_DLY + 1);

    loc_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          est_q, est_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_FREE;
            cnt_q   <= '0;
            est_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            est_q   <= est_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LS_FREE: begin
                if (req_i && !rel_i) begin
                    state_d = LS_PEND;
                    cnt_d   = '0;
                end
            end
            LS_PEND: begin
                if (rel_i)
                    state_d = LS_FREE;
                else if (cnt_q == CW'(GRANT_DLY - 1))
                    state_d = LS_OWNED;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            LS_OWNED: begin
                if (rel_i)
                    state_d = LS_FREE;
            end
            default: state_d = LS_FREE;
        endcase
        est_d = est_q | (state_d == LS_OWNED);
    end

    always_comb begin
        owned_o = (state_q == LS_OWNED);
        valid_o = (state_q != LS_PEND);
        estab_o = est_q;
    end

    AST_GRANT_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owned_o) |-> $past(state_q == LS_PEND)); // R2
    AST_RELINQUISH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |=> !owned_o); // R3

endmodule

// File: rtl/crb_ctrl_fsm.sv
module crb_ctrl_fsm
    import crb_pkg::*;
#(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_set_i,
    input  logic             start_i,
    input  logic             cancel_i,
    input  logic [LAT_W-1:0] lat_i,
    output ctrl_state_e      state_o,
    output logic [1:0]       req_o,
    output logic             err_o,
    output logic             done_o
);
    ctrl_state_e      state_q, state_d;
    logic [LAT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       req_q, req_d;
    logic             err_q, err_d;
    logic             req_clr, start_rej, done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            req_q   <= 2'b00;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            req_q   <= req_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        req_clr   = 1'b0;
        start_rej = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                req_clr   = |req_q;
                start_rej = start_i;
                if (req_q[0])
                    state_d = CS_READY;
            end
            CS_READY: begin
                req_clr = |req_q;
                if (req_q[1]) begin
                    state_d   = CS_IDLE;
                    start_rej = start_i;
                end else if (start_i) begin
                    state_d = CS_EXEC;
                    cnt_d   = lat_i;
                end
            end
            CS_EXEC: begin
                start_rej = start_i;
                if (cancel_i) begin
                    state_d = CS_READY;
                end else if (cnt_q == '0) begin
                    state_d = CS_READY;
                    done    = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = CS_IDLE;
        endcase
        if (state_q == CS_READY && state_d == CS_IDLE)
            err_d = 1'b0;
        else if (start_rej)
            err_d = 1'b1;
        else
            err_d = err_q;
        req_d = (req_clr ? 2'b00 : req_q) | req_set_i;
    end

    always_comb begin
        state_o = state_q;
        req_o   = req_q;
        err_o   = err_q;
        done_o  = done;
    end

    AST_EXEC_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_EXEC && $past(state_q) != CS_EXEC)
            |-> ($past(state_q) == CS_READY && $past(start_i))); // R5
    AST_CANCEL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_EXEC && cancel_i) |=> (state_q == CS_READY)); // R7
    AST_REQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CS_EXEC && req_q != 2'b00 && req_set_i == 2'b00)
            |=> (req_q == 2'b00)); // R4
    AST_IDLE_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == CS_READY && state_q == CS_IDLE) |-> !err_q); // R6

endmodule

// File: rtl/crb_buffer.sv
module crb_buffer
    import crb_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    localparam int WORDS = BUF_BYTES / 4,
    localparam int WIX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIX_W-1:0] widx_i,
    input  logic [31:0]      wdata_i,
    input  logic             hdr_i,
    input  logic [WIX_W-1:0] ridx_i,
    output logic [31:0]      rdata_o
);
    logic [8*BUF_BYTES-1:0] mem_q;
    logic [31:0]            word_arr [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int b = 0; b < BUF_BYTES; b++) begin
                if (hdr_i && b < HDR_BYTES)
                    mem_q[8*b +: 8] <= hdr_byte(b);
                else if (wr_i && widx_i == WIX_W'(b / 4))
                    mem_q[8*b +: 8] <= wdata_i[8*(b % 4) +: 8];
            end
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign word_arr[g] = mem_q[32*g +: 32];
    end

    assign rdata_o = word_arr[ridx_i];

    AST_HDR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_i |-> !wr_i); // R10

endmodule

// File: rtl/crb_regslave.sv
module crb_regslave
    import crb_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          BUF_BYTES = 32,
    parameter int          GRANT_DLY = 4,
    parameter int          LAT_W     = 16,
    parameter logic [63:0] BUF_BASE  = 64'h0000_0001_FED4_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LAT_W-1:0]  exec_cycles
);
    localparam int          WORDS    = BUF_BYTES / 4;
    localparam int          WIX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [63:0] WIN_ADDR = BUF_BASE + 64'h80;

    logic [ADDR_W-1:0] waddr, woff;
    logic              in_win, wr_owned;
    logic              loc_owned, loc_valid, loc_estab;
    ctrl_state_e       ctrl_state;
    logic [1:0]        req_bits, req_set;
    logic              err_flag, exec_done, start_wr;
    logic              cancel_q, ien_q, buf_wr;
    logic [WIX_W-1:0]  widx;
    logic [31:0]       buf_rd;

    assign waddr    = bus_addr & ~ADDR_W'(3);
    assign in_win   = ({1'b0, waddr} >= (ADDR_W+1)'(OFS_DATA))
                   && ({1'b0, waddr} <  (ADDR_W+1)'(OFS_DATA + BUF_BYTES));
    assign woff     = waddr - ADDR_W'(OFS_DATA);
    assign widx     = WIX_W'(woff >> 2);
    assign wr_owned = bus_wr && loc_owned;

    assign req_set  = (wr_owned && waddr == ADDR_W'(OFS_REQ)) ? bus_wdata[1:0] : 2'b00;
    assign start_wr = wr_owned && waddr == ADDR_W'(OFS_START) && bus_wdata[0];
    assign buf_wr   = wr_owned && in_win && (ctrl_state != CS_EXEC);

    crb_locality #(.GRANT_DLY(GRANT_DLY)) u_loc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (bus_wr && waddr == ADDR_W'(OFS_LOC_CTRL) && bus_wdata[0]),
        .rel_i   (bus_wr && waddr == ADDR_W'(OFS_LOC_CTRL) && bus_wdata[1]),
        .owned_o (loc_owned),
        .valid_o (loc_valid),
        .estab_o (loc_estab)
    );

    crb_ctrl_fsm #(.LAT_W(LAT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_set_i (req_set),
        .start_i   (start_wr),
        .cancel_i  (cancel_q),
        .lat_i     (exec_cycles),
        .state_o   (ctrl_state),
        .req_o     (req_bits),
        .err_o     (err_flag),
        .done_o    (exec_done)
    );

    crb_buffer #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (buf_wr),
        .widx_i  (widx),
        .wdata_i (bus_wdata),
        .hdr_i   (exec_done),
        .ridx_i  (widx),
        .rdata_o (buf_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cancel_q <= 1'b0;
            ien_q    <= 1'b0;
        end else begin
            if (wr_owned && waddr == ADDR_W'(OFS_CANCEL))
                cancel_q <= bus_wdata[0];
            if (bus_wr && waddr == ADDR_W'(OFS_IEN))
                ien_q <= bus_wdata[31];
        end
    end

    always_comb begin
        bus_rdata = 32'h0;
        if (in_win) begin
            bus_rdata = buf_rd;
        end else begin
            case (waddr)
                ADDR_W'(OFS_LOC_STATE): bus_rdata = {24'h0, loc_valid, 5'h0, loc_owned, loc_estab};
                ADDR_W'(OFS_LOC_STS):   bus_rdata = {31'h0, loc_owned};
                ADDR_W'(OFS_IFACE_ID):  bus_rdata = 32'h1;
                ADDR_W'(OFS_CTRL_EXT):  bus_rdata = 32'h0;
                ADDR_W'(OFS_REQ):       bus_rdata = {30'h0, req_bits};
                ADDR_W'(OFS_STS):       bus_rdata = {30'h0, ctrl_state == CS_IDLE, err_flag};
                ADDR_W'(OFS_CANCEL):    bus_rdata = {31'h0, cancel_q};
                ADDR_W'(OFS_START):     bus_rdata = {31'h0, ctrl_state == CS_EXEC};
                ADDR_W'(OFS_IEN):       bus_rdata = {ien_q, 31'h0};
                ADDR_W'(OFS_ISTS):      bus_rdata = 32'h0;
                ADDR_W'(OFS_CMD_SIZE):  bus_rdata = 32'(BUF_BYTES);
                ADDR_W'(OFS_RSP_SIZE):  bus_rdata = 32'(BUF_BYTES);
                ADDR_W'(OFS_CMD_LO):    bus_rdata = WIN_ADDR[31:0];
                ADDR_W'(OFS_RSP_LO):    bus_rdata = WIN_ADDR[31:0];
                ADDR_W'(OFS_CMD_HI):    bus_rdata = WIN_ADDR[63:32];
                ADDR_W'(OFS_RSP_HI):    bus_rdata = WIN_ADDR[63:32];
                default:                bus_rdata = 32'h0;
            endcase
        end
    end

    AST_START_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == CS_EXEC && $past(ctrl_state) != CS_EXEC) |-> $past(loc_owned)); // R9

endmodule

// File: tb/crb_regslave_bench.sv
module crb_regslave_bench;
    localparam int          BB   = 32;
    localparam int          GD   = 4;
    localparam logic [63:0] BASE = 64'h0000_0001_FED4_0000;
    localparam logic [63:0] WIN  = BASE + 64'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [15:0] exec_cycles = 16'h0;

    always #10 clk = ~clk;

    crb_regslave #(.ADDR_W(8), .BUF_BYTES(BB), .GRANT_DLY(GD), .LAT_W(16), .BUF_BASE(BASE))
        u_crb_regslave (
            .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
            .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exec_cycles(exec_cycles));

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference: locality 0 free 1 pending 2 owned; control 0 idle 1 ready 2 exec
    int         m_loc, m_ld, m_st, m_cnt;
    bit         m_est, m_err, m_can, m_ien;
    bit [1:0]   m_req;
    logic [7:0] m_buf [BB];
    int         n_loc, n_ld, n_st, n_cnt;
    bit         n_err, ok, start, hdr;
    bit [1:0]   n_req;
    int         a;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_loc = 0; m_ld = 0; m_st = 0; m_cnt = 0;
            m_est = 0; m_err = 0; m_can = 0; m_ien = 0; m_req = 2'b00;
            for (int i = 0; i < BB; i++) m_buf[i] = 8'h00;
        end else begin
            a     = int'(bus_addr) & 'hFC;
            ok    = bus_wr && (m_loc == 2);
            n_loc = m_loc; n_ld = m_ld;
            if (m_loc == 1) begin
                if (m_ld == GD - 1) n_loc = 2; else n_ld = m_ld + 1;
            end
            if (bus_wr && a == 'h08) begin
                if (bus_wdata[1]) n_loc = 0;
                else if (bus_wdata[0] && m_loc == 0) begin n_loc = 1; n_ld = 0; end
            end
            start = ok && a == 'h4C && bus_wdata[0];
            n_st = m_st; n_cnt = m_cnt; n_err = m_err; n_req = m_req; hdr = 0;
            if (m_st == 0) begin
                if (m_req[0]) n_st = 1;
                n_req = 2'b00;
                if (start) n_err = 1;
            end else if (m_st == 1) begin
                n_req = 2'b00;
                if (m_req[1]) begin
                    n_st = 0;
                end else if (start) begin
                    n_st = 2; n_cnt = int'(exec_cycles);
                end
                if (start && m_req[1]) n_err = 1;
                if (m_req[1]) n_err = 0;
            end else begin
                if (start) n_err = 1;
                if (m_can) n_st = 1;
                else if (m_cnt == 0) begin n_st = 1; hdr = 1; end
                else n_cnt = m_cnt - 1;
            end
            if (ok && a == 'h40) n_req = n_req | bus_wdata[1:0];
            if (ok && a == 'h48) m_can = bus_wdata[0];
            if (bus_wr && a == 'h50) m_ien = bus_wdata[31];
            if (ok && m_st != 2 && a >= 'h80 && a < 'h80 + BB)
                for (int k = 0; k < 4; k++) m_buf[a - 'h80 + k] = bus_wdata[8*k +: 8];
            if (hdr) begin
                for (int k = 0; k < 10; k++) m_buf[k] = 8'h00;
                m_buf[0] = 8'h80; m_buf[1] = 8'h01; m_buf[5] = 8'd10;
            end
            if (n_loc == 2) m_est = 1;
            m_loc = n_loc; m_ld = n_ld; m_st = n_st; m_cnt = n_cnt;
            m_err = n_err; m_req = n_req;
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] addr);
        int x;
        x = int'(addr) & 'hFC;
        if (x >= 'h80 && x < 'h80 + BB)
            return {m_buf[x-'h80+3], m_buf[x-'h80+2], m_buf[x-'h80+1], m_buf[x-'h80]};
        case (x)
            'h00: return {24'h0, m_loc != 1, 5'h0, m_loc == 2, m_est};
            'h0C: return {31'h0, m_loc == 2};
            'h30: return 32'h1;
            'h40: return {30'h0, m_req};
            'h44: return {30'h0, m_st == 0, m_err};
            'h48: return {31'h0, m_can};
            'h4C: return {31'h0, m_st == 2};
            'h50: return {m_ien, 31'h0};
            'h58, 'h64: return 32'(BB);
            'h5C, 'h68: return WIN[31:0];
            'h60, 'h6C: return WIN[63:32];
            default: return 32'h0;
        endcase
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_chk++;
            if (bus_rdata !== m_read(bus_addr)) begin
                n_fail++;
                $display("FAIL %s per-cycle addr %h actual %h expected %h",
                         cur_req, bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    task automatic chk(input logic [7:0] ad, input logic [31:0] exp, input string tag);
        bus_addr = ad; bus_wr = 1'b0; cur_req = tag;
        @(negedge clk);
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr %h actual %h expected %h", tag, ad, bus_rdata, exp);
        end
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] ad, input logic [31:0] d, input string tag);
        bus_addr = ad; bus_wdata = d; bus_wr = 1'b1; cur_req = tag;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired, actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset values and descriptors
        chk(8'h00, 32'h80, "R1");
        chk(8'h44, 32'h2, "R1");
        chk(8'h4C, 32'h0, "R1");
        chk(8'h30, 32'h1, "R1");
        chk(8'h58, 32'd32, "R1");
        chk(8'h64, 32'd32, "R1");
        chk(8'h5C, 32'hFED4_0080, "R1");
        chk(8'h60, 32'h1, "R1");
        chk(8'h68, 32'hFED4_0080, "R1");
        chk(8'h6C, 32'h1, "R1");
        // R9 writes without the locality
        wr(8'h40, 32'h1, "R9");
        wr(8'h4C, 32'h1, "R9");
        wr(8'h80, 32'h1234_5678, "R9");
        chk(8'h40, 32'h0, "R9");
        chk(8'h44, 32'h2, "R9");
        chk(8'h80, 32'h0, "R9");
        // R2 grant timing
        wr(8'h08, 32'h1, "R2");
        chk(8'h00, 32'h00, "R2");
        idle(2);
        chk(8'h00, 32'h00, "R2");
        chk(8'h00, 32'h83, "R2");
        chk(8'h0C, 32'h1, "R2");
        // R11 interrupt enable, read-only and unmapped
        wr(8'h50, 32'hFFFF_FFFF, "R11");
        chk(8'h50, 32'h8000_0000, "R11");
        wr(8'h50, 32'h7FFF_FFFF, "R11");
        chk(8'h50, 32'h0, "R11");
        wr(8'h30, 32'h0, "R11");
        chk(8'h30, 32'h1, "R11");
        wr(8'h58, 32'h0, "R11");
        chk(8'h58, 32'd32, "R11");
        chk(8'h10, 32'h0, "R11");
        // R4 go ready with self-clearing request
        wr(8'h40, 32'h1, "R4");
        chk(8'h40, 32'h1, "R4");
        chk(8'h40, 32'h0, "R4");
        chk(8'h44, 32'h0, "R4");
        // R5 latency 5, R10 write during execution, R8 header
        wr(8'h88, 32'hAABB_CCDD, "R8");
        wr(8'h8C, 32'h1122_3344, "R8");
        wr(8'h80, 32'hFFFF_FFFF, "R8");
        exec_cycles = 16'd5;
        wr(8'h4C, 32'h1, "R5");
        chk(8'h4C, 32'h1, "R5");
        wr(8'h8C, 32'h0, "R10");
        idle(2);
        chk(8'h4C, 32'h1, "R5");
        chk(8'h4C, 32'h1, "R5");
        chk(8'h4C, 32'h0, "R5");
        chk(8'h80, 32'h0000_0180, "R8");
        chk(8'h84, 32'h0000_0A00, "R8");
        chk(8'h88, 32'hAABB_0000, "R8");
        chk(8'h8C, 32'h1122_3344, "R10");
        chk(8'h44, 32'h0, "R5");
        // R7 cancel during a long command
        exec_cycles = 16'd100;
        wr(8'h84, 32'h5555_5555, "R7");
        wr(8'h4C, 32'h1, "R7");
        idle(3);
        wr(8'h48, 32'h1, "R7");
        chk(8'h4C, 32'h1, "R7");
        chk(8'h4C, 32'h0, "R7");
        chk(8'h84, 32'h5555_5555, "R7");
        chk(8'h44, 32'h0, "R7");
        chk(8'h48, 32'h1, "R7");
        wr(8'h48, 32'h0, "R7");
        chk(8'h48, 32'h0, "R7");
        // R6 dropped start sets error, idle clears it
        wr(8'h40, 32'h2, "R6");
        chk(8'h40, 32'h2, "R6");
        chk(8'h44, 32'h2, "R6");
        wr(8'h4C, 32'h1, "R6");
        chk(8'h44, 32'h3, "R6");
        chk(8'h4C, 32'h0, "R6");
        wr(8'h40, 32'h1, "R6");
        chk(8'h40, 32'h1, "R6");
        chk(8'h44, 32'h1, "R6");
        wr(8'h40, 32'h2, "R6");
        chk(8'h40, 32'h2, "R6");
        chk(8'h44, 32'h2, "R6");
        // R5 zero latency boundary, R8 header rewritten
        wr(8'h40, 32'h1, "R5");
        idle(1);
        exec_cycles = 16'd0;
        wr(8'h4C, 32'h1, "R5");
        chk(8'h4C, 32'h1, "R5");
        chk(8'h4C, 32'h0, "R5");
        chk(8'h84, 32'h0000_0A00, "R8");
        // R3 relinquish, priority over request, during pending
        wr(8'h08, 32'h2, "R3");
        chk(8'h0C, 32'h0, "R3");
        chk(8'h00, 32'h81, "R3");
        wr(8'h08, 32'h3, "R3");
        chk(8'h00, 32'h81, "R3");
        wr(8'h4C, 32'h1, "R9");
        chk(8'h4C, 32'h0, "R9");
        chk(8'h44, 32'h0, "R9");
        wr(8'h08, 32'h1, "R3");
        chk(8'h00, 32'h01, "R3");
        wr(8'h08, 32'h2, "R3");
        chk(8'h00, 32'h81, "R3");
        idle(GD + 1);
        chk(8'h00, 32'h81, "R3");
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule